// File: doc/BRIEF.md
# Temperature Alarm Event Generator

This block watches a stream of digitized temperature samples and decides when a thermal event must be signalled. Each new conversion arrives with a strobe. The block compares the sample against three programmable limits: an upper limit, a lower limit and a critical limit. It keeps one status flag per limit and drives an active-low event line. The event line is modelled as a low-level data value plus an output enable, so that an open-drain pad can be built from it outside the block.

Software loads the limits and a configuration byte through a plain parallel write port. The configuration sets the following:
- the effective conversion resolution, from 9 to 12 bits, with the default at 10 bits;
- one of four hysteresis amounts, applied when a flag clears;
- whether the event line follows the live condition (comparator mode) or latches new alarms until it is cleared (interrupt mode);
- whether only the critical limit may raise the event;
- a global enable for the event line.

All values are 13-bit two's complement in steps of 1/16 °C, which covers the full −40 °C to +125 °C range.

Top module: `tempalarm_evt`

## Requirements
- R1: After reset all three status flags are 0, evt_n is 1 and evt_oe is 0. All limits reset to 0. The configuration resets to 10-bit resolution (resolution code 1) with every other field 0.
- R2: The configuration byte holds the resolution code in bits [7:6]. Codes 0, 1, 2 and 3 select 9, 10, 11 and 12 bits. Before any comparison, the lowest 3 − code bits of the sample and of every limit are forced to zero.
- R3: On a sample whose masked value is above the masked upper limit, above_upper is set.
- R4: On a sample whose masked value is below the masked lower limit, below_lower is set.
- R5: On a sample whose masked value is above the masked critical limit, above_crit is set.
- R6: Configuration bits [5:4] select the hysteresis: 0, 24, 48 or 96 LSB (0, 1.5, 3 and 6 °C). A set flag clears only on a sample that meets the clearing bound for its limit. For the upper and critical flags, the bound is a sample at or below the limit minus the hysteresis. For the lower flag, the bound is a sample at or above the limit plus the hysteresis.
- R7: The status flags change only in the cycle after a strobed sample. Writes to limits or configuration leave them unchanged. Every result appears one clock after the edge that captures its input.
- R8: With bit 1 clear (comparator mode), the event is active exactly while any selected status flag is set.
- R9: With bit 2 set (critical-only), only above_crit can make the event active or latch it.
- R10: With bit 1 set (interrupt mode), a selected flag going from 0 to 1 latches the event. The latch holds until a configuration write that has bit 3 set or bit 1 clear. Bit 3 is never stored.
- R11: In interrupt mode, the event stays active while above_crit is set, even after a clear.
- R12: With bit 0 (event enable) clear, evt_n is 1 and evt_oe is 0, and the status flags keep updating.
- R13: evt_oe is 1 exactly when evt_n is 0. The write select codes are 0 for configuration, 1 for upper, 2 for lower and 3 for critical. Limits take wr_data[12:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 13 | Write data (configuration in [7:0], limits in [12:0]) |
| samp_valid | input | 1 | Marks a new temperature sample |
| samp_temp | input | 13 | Signed temperature sample, 1/16 °C per LSB |
| evt_n | output | 1 | Active-low event level |
| evt_oe | output | 1 | Drive enable for the event pad (pull low) |
| above_upper | output | 1 | Upper-limit status flag |
| below_lower | output | 1 | Lower-limit status flag |
| above_crit | output | 1 | Critical-limit status flag |

## Verification
Every result is registered exactly once. A sample or a register write captured at one rising edge shows in the status flags and in the event pins just after that edge, and in no earlier or later cycle. The bench drives stimulus on the falling edge. It checks the next falling edge against a behavioural model that updates on the rising edge in between, so each comparison lands exactly one cycle after its stimulus. Directed sequences place samples on the hysteresis bounds and on the masking boundaries, and exercise the latch and clear cases. A long random phase then compares all five outputs on every cycle.

// File: rtl/tempalarm_pkg.sv
package tempalarm_pkg;

  // Configuration byte layout; the position of each field is behaviour.
  typedef struct packed {
    logic [1:0] res;        // resolution code: 0=9b .. 3=12b
    logic [1:0] hyst;       // hysteresis code
    logic       clr;        // write-one-to-clear of the latch, never stored
    logic       crit_only;  // only the critical limit drives the event
    logic       int_mode;   // 1 = latched interrupt, 0 = comparator
    logic       evt_en;     // global event enable
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [1:0] {
    SEL_CFG   = 2'd0,
    SEL_UPPER = 2'd1,
    SEL_LOWER = 2'd2,
    SEL_CRIT  = 2'd3
  } sel_e;

  localparam int N_LIM     = 3;
  localparam int IDX_UPPER = 0;
  localparam int IDX_LOWER = 1;
  localparam int IDX_CRIT  = 2;

  localparam cfg_t CFG_RST = '{res: 2'd1, hyst: 2'd0, clr: 1'b0,
                               crit_only: 1'b0, int_mode: 1'b0, evt_en: 1'b0};

endpackage

// File: rtl/tempalarm_regs.sv
module tempalarm_regs
  import tempalarm_pkg::*;
#(
  parameter int TEMP_W = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_sel,
  input  logic [TEMP_W-1:0]            wr_data,
  output cfg_t                         cfg_q,
  output logic [N_LIM-1:0][TEMP_W-1:0] lim_q,
  output logic                         int_clr
);

  cfg_t             cfg_d;
  cfg_t             wcfg;
  logic             cfg_we;
  logic [N_LIM-1:0] lim_we;

  // next-state for the configuration register
  always_comb begin
    wcfg    = cfg_t'(wr_data[CFG_W-1:0]);
    cfg_we  = wr_en && (wr_sel == SEL_CFG);
    cfg_d   = wcfg;
    cfg_d.clr = 1'b0;
    int_clr = cfg_we && (wcfg.clr || !wcfg.int_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  // one limit register per select code 1..N_LIM
  for (genvar i = 0; i < N_LIM; i++) begin : g_lim
    always_comb lim_we[i] = wr_en && (wr_sel == 2'(i + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lim_q[i] <= '0;
      end else if (lim_we[i]) begin
        lim_q[i] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/tempalarm_lim.sv
module tempalarm_lim #(
  parameter int TEMP_W = 13,
  parameter bit ABOVE  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] limit,
  input  logic [TEMP_W-1:0] hyst,
  output logic              flag_q,
  output logic              rise
);

  localparam int EW = TEMP_W + 2;

  logic signed [EW-1:0] t_x;
  logic signed [EW-1:0] l_x;
  logic signed [EW-1:0] h_x;
  logic                 trip;
  logic                 release_ok;
  logic                 flag_d;

  always_comb begin
    t_x = EW'($signed(temp));
    l_x = EW'($signed(limit));
    h_x = $signed({2'b00, hyst});
  end

  if (ABOVE) begin : g_above
    always_comb begin
      trip       = t_x > l_x;
      release_ok = t_x <= (l_x - h_x);
    end
  end else begin : g_below
    always_comb begin
      trip       = t_x < l_x;
      release_ok = t_x >= (l_x + h_x);
    end
  end

  // hysteresis only on the way out
  always_comb begin
    flag_d = flag_q ? !release_ok : trip;
    rise   = samp_valid && flag_d && !flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (samp_valid) begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/tempalarm_evtgen.sv
module tempalarm_evtgen
  import tempalarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic [N_LIM-1:0] flags,
  input  logic [N_LIM-1:0] rises,
  input  logic             int_clr,
  output logic             int_q,
  output logic             evt_n,
  output logic             evt_oe
);

  logic [N_LIM-1:0] sel_mask;
  logic             alarm;
  logic             rise_any;
  logic             int_set;
  logic             int_we;
  logic             int_d;
  logic             active;
  logic             drive;

  always_comb begin
    sel_mask = cfg.crit_only ? (N_LIM'(1) << IDX_CRIT) : '1;
    alarm    = |(flags & sel_mask);
    rise_any = |(rises & sel_mask);
    int_set  = cfg.int_mode && rise_any;
    int_we   = int_set || int_clr;
    int_d    = (int_q && !int_clr) || int_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= 1'b0;
    end else if (int_we) begin
      int_q <= int_d;
    end
  end

  always_comb begin
    active = cfg.int_mode ? (int_q || flags[IDX_CRIT]) : alarm;
    drive  = cfg.evt_en && active;
    evt_n  = !drive;
    evt_oe = drive;
  end

endmodule

// File: rtl/tempalarm_evt.sv
module tempalarm_evt
  import tempalarm_pkg::*;
#(
  parameter int TEMP_W = 13,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [TEMP_W-1:0] wr_data,
  input  logic              samp_valid,
  input  logic [TEMP_W-1:0] samp_temp,
  output logic              evt_n,
  output logic              evt_oe,
  output logic              above_upper,
  output logic              below_lower,
  output logic              above_crit
);

  localparam int              MAX_DROP  = FRAC_W - 1;
  localparam logic [TEMP_W-1:0] HYST_BASE = TEMP_W'(3 << (FRAC_W - 1));

  logic [1:0]                   rst_pipe;
  logic                         rst_sync_n;
  cfg_t                         cfg_q;
  logic [N_LIM-1:0][TEMP_W-1:0] lim_q;
  logic                         int_clr;
  logic                         int_q;
  logic [2:0]                   drop;
  logic [TEMP_W-1:0]            res_mask;
  logic [TEMP_W-1:0]            hyst_amt;
  logic [TEMP_W-1:0]            temp_m;
  logic [N_LIM-1:0]             flags;
  logic [N_LIM-1:0]             rises;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  tempalarm_regs #(.TEMP_W(TEMP_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cfg_q   (cfg_q),
    .lim_q   (lim_q),
    .int_clr (int_clr)
  );

  // resolution masking and hysteresis amount
  always_comb begin
    drop     = 3'(MAX_DROP) - {1'b0, cfg_q.res};
    res_mask = {TEMP_W{1'b1}} << drop;
    temp_m   = samp_temp & res_mask;
    hyst_amt = (cfg_q.hyst == 2'd0) ? '0 : (HYST_BASE << (cfg_q.hyst - 2'd1));
  end

  for (genvar i = 0; i < N_LIM; i++) begin : g_cmp
    tempalarm_lim #(
      .TEMP_W (TEMP_W),
      .ABOVE  (i != IDX_LOWER)
    ) lim_i (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .samp_valid (samp_valid),
      .temp       (temp_m),
      .limit      (lim_q[i] & res_mask),
      .hyst       (hyst_amt),
      .flag_q     (flags[i]),
      .rise       (rises[i])
    );
  end

  tempalarm_evtgen evtgen_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cfg     (cfg_q),
    .flags   (flags),
    .rises   (rises),
    .int_clr (int_clr),
    .int_q   (int_q),
    .evt_n   (evt_n),
    .evt_oe  (evt_oe)
  );

  assign above_upper = flags[IDX_UPPER];
  assign below_lower = flags[IDX_LOWER];
  assign above_crit  = flags[IDX_CRIT];

endmodule

// File: rtl/tempalarm_chk.sv
module tempalarm_chk #(
  parameter int TEMP_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              samp_valid,
  input logic [TEMP_W-1:0] samp_temp,
  input logic [TEMP_W-1:0] upper,
  input logic [TEMP_W-1:0] lower,
  input logic [TEMP_W-1:0] crit,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic              evt_en,
  input logic              int_q,
  input logic              st_up,
  input logic              st_lo,
  input logic              st_cr,
  input logic              evt_n,
  input logic              evt_oe
);

  localparam int EW = TEMP_W + 2;

  logic signed [EW-1:0] t_x;
  logic signed [EW-1:0] u_x;
  logic signed [EW-1:0] l_x;
  logic signed [EW-1:0] c_x;

  always_comb begin
    t_x = EW'($signed(samp_temp));
    u_x = EW'($signed(upper));
    l_x = EW'($signed(lower));
    c_x = EW'($signed(crit));
  end

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(samp_valid) |-> $stable({st_up, st_lo, st_cr}));  // R7

  AST_UP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && (t_x > u_x + 8)) |=> st_up);  // R3

  AST_LO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && (t_x < l_x - 8)) |=> st_lo);  // R4

  AST_CR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && (t_x > c_x + 8)) |=> st_cr);  // R5

  AST_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_en |-> (evt_n && !evt_oe));  // R12

  AST_CRIT_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_en && st_cr) |-> !evt_n);  // R11

  AST_INT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q && !(wr_en && wr_sel == 2'd0)) |=> int_q);  // R10

endmodule

bind tempalarm_evt tempalarm_chk #(.TEMP_W(TEMP_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .samp_valid (samp_valid),
  .samp_temp  (samp_temp),
  .upper      (lim_q[0]),
  .lower      (lim_q[1]),
  .crit       (lim_q[2]),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .evt_en     (cfg_q.evt_en),
  .int_q      (int_q),
  .st_up      (above_upper),
  .st_lo      (below_lower),
  .st_cr      (above_crit),
  .evt_n      (evt_n),
  .evt_oe     (evt_oe)
);

// File: tb/tempalarm_evt_tb_top.sv
`timescale 1ns/1ps
module tempalarm_evt_tb_top;

  localparam int TW = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [1:0]    wr_sel;
  logic [TW-1:0] wr_data;
  logic          samp_valid;
  logic [TW-1:0] samp_temp;
  logic          evt_n, evt_oe, above_upper, below_lower, above_crit;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  tempalarm_evt dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .samp_valid(samp_valid), .samp_temp(samp_temp), .evt_n(evt_n), .evt_oe(evt_oe),
    .above_upper(above_upper), .below_lower(below_lower), .above_crit(above_crit)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_res, m_hys, m_co, m_im, m_en;
  int m_u, m_l, m_c;
  bit m_su, m_sl, m_sc, m_il;

  function automatic int sx(logic [TW-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int m_evt_n();
    bit act;
    if (m_im != 0) act = m_il || m_sc;
    else if (m_co != 0) act = m_sc;
    else act = m_su || m_sl || m_sc;
    return (m_en != 0 && act) ? 0 : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int mk, t, u, l, c, h;
    bit nu, nl, nc, rise, clr;
    if (!rst_n) begin
      m_res = 1; m_hys = 0; m_co = 0; m_im = 0; m_en = 0;
      m_u = 0; m_l = 0; m_c = 0;
      m_su = 0; m_sl = 0; m_sc = 0; m_il = 0;
    end else begin
      nu = m_su; nl = m_sl; nc = m_sc; rise = 0; clr = 0;
      if (samp_valid) begin
        mk = ~((1 << (3 - m_res)) - 1);
        t = sx(samp_temp) & mk;
        u = m_u & mk; l = m_l & mk; c = m_c & mk;
        h = (m_hys == 0) ? 0 : (24 << (m_hys - 1));
        nu = m_su ? !(t <= u - h) : (t > u);
        nl = m_sl ? !(t >= l + h) : (t < l);
        nc = m_sc ? !(t <= c - h) : (t > c);
        if (m_co != 0) rise = nc && !m_sc;
        else rise = (nu && !m_su) || (nl && !m_sl) || (nc && !m_sc);
      end
      if (wr_en && wr_sel == 2'd0) clr = wr_data[3] || !wr_data[1];
      m_il = (m_il && !clr) || (m_im != 0 && rise);
      m_su = nu; m_sl = nl; m_sc = nc;
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin
            m_en = wr_data[0]; m_im = wr_data[1]; m_co = wr_data[2];
            m_hys = int'(wr_data[5:4]); m_res = int'(wr_data[7:6]);
          end
          2'd1: m_u = sx(wr_data);
          2'd2: m_l = sx(wr_data);
          default: m_c = sx(wr_data);
        endcase
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R3 above_upper vs model", above_upper, m_su);
      chk("R4 below_lower vs model", below_lower, m_sl);
      chk("R5 above_crit vs model", above_crit, m_sc);
      chk("R8 evt_n vs model", evt_n, m_evt_n());
      chk("R13 evt_oe vs model", evt_oe, 1 - m_evt_n());
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(int sel, int data);
    wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = data[TW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic samp(int t);
    samp_valid = 1'b1; samp_temp = t[TW-1:0];
    @(negedge clk);
    samp_valid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    samp_valid = 1'b0; samp_temp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    chk("R1 above_upper", above_upper, 0);
    chk("R1 below_lower", below_lower, 0);
    chk("R1 above_crit", above_crit, 0);
    chk("R1 evt_n", evt_n, 1);
    chk("R1 evt_oe", evt_oe, 0);

    // R1/R2: default 10-bit masks sample 3 down to 0, not above limit 0
    samp(3);
    chk("R2 default res masks low bits", above_upper, 0);
    chk("R5 crit limit 0 not exceeded", above_crit, 0);

    wr(1, 100); wr(2, -16); wr(3, 400);
    samp(103);
    chk("R2 10-bit 103 masked to 100", above_upper, 0);

    wr(0, 'hC1);   // 12-bit, enabled, comparator
    chk("R7 cfg write leaves flag", above_upper, 0);
    samp(101);
    chk("R3 101 above 100", above_upper, 1);
    chk("R8 comparator event", evt_n, 0);
    chk("R13 oe drives low", evt_oe, 1);
    wr(1, 50);
    chk("R7 limit write leaves flag", above_upper, 1);
    wr(1, 100);
    samp(50);
    chk("R3 clears at 50", above_upper, 0);
    chk("R8 event released", evt_n, 1);

    samp(-17);
    chk("R4 -17 below -16", below_lower, 1);
    samp(-16);
    chk("R4 clears at limit", below_lower, 0);

    wr(0, 'hD1);   // hysteresis 24
    samp(101);
    samp(77);
    chk("R6 hyst24 holds at 77", above_upper, 1);
    samp(76);
    chk("R6 hyst24 clears at 76", above_upper, 0);
    wr(0, 'hF1);   // hysteresis 96
    samp(101);
    samp(5);
    chk("R6 hyst96 holds at 5", above_upper, 1);
    samp(4);
    chk("R6 hyst96 clears at 4", above_upper, 0);

    wr(0, 'hC5);   // critical only
    samp(200);
    chk("R9 upper flag set", above_upper, 1);
    chk("R9 no event from upper", evt_n, 1);
    samp(401);
    chk("R9 critical raises event", evt_n, 0);
    samp(50);
    chk("R9 released", evt_n, 1);

    wr(0, 'hC3);   // interrupt mode
    samp(150);
    chk("R10 latch on new alarm", evt_n, 0);
    samp(50);
    chk("R10 flag cleared", above_upper, 0);
    chk("R10 event stays latched", evt_n, 0);
    wr(0, 'hCB);
    chk("R10 clear releases", evt_n, 1);

    samp(450);
    chk("R11 crit set", above_crit, 1);
    wr(0, 'hCB);
    chk("R11 crit holds event through clear", evt_n, 0);
    samp(300);
    chk("R11 releases when crit drops", evt_n, 1);

    wr(0, 'hC0);   // disabled
    samp(450);
    chk("R12 status still updates", above_crit, 1);
    chk("R12 evt_n held high", evt_n, 1);
    chk("R12 evt_oe held low", evt_oe, 0);
    wr(0, 'hC1);
    chk("R12 enable shows event", evt_n, 0);

    wr(0, 'h01);   // 9-bit
    samp(103);
    chk("R2 9-bit 103 vs 100 equal after mask", above_upper, 0);
    samp(104);
    chk("R2 9-bit 104 above", above_upper, 1);

    // random phase, checked every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(99, 0));
      samp_valid = (r < 35);
      samp_temp  = TW'(int'($urandom_range(2800, 0)) - 700);
      wr_en      = (r > 88);
      wr_sel     = 2'($urandom_range(3, 0));
      if (wr_sel == 2'd0) wr_data = TW'($urandom_range(255, 0));
      else wr_data = TW'(int'($urandom_range(2640, 0)) - 640);
      @(negedge clk);
    end
    samp_valid = 1'b0; wr_en = 1'b0;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule